// File: doc/BRIEF.md
# DMA Transfer Shape Registers

This block is the slice of a two-ported DMA engine's control registers that holds the shape of a transfer. It stores four values: the row length, the row count for two-dimensional transfers, the source stride and the destination stride. It fixes their alignment in hardware at the moment they are stored. The length fields are stored as byte count minus one. Their low bits are held at one, so every length is a whole number of beats on the widest port that needs alignment. The two sides of the engine therefore always agree on the total size of a transfer. The stride fields hold their low bits at zero, so the addresses derived from them stay on beat boundaries of their own port.

Software writes the registers through a plain word-addressed register bus that has per-byte strobes, and it reads them back one cycle after a read strobe. Readback always returns the aligned value. Writing zero to the length register and reading it back therefore shows software the alignment in force. The transfer engine takes the four aligned values directly from dedicated outputs. The port kinds (memory-mapped, streaming or FIFO) and the port data widths are build-time parameters.

Top module: `dma_shape_regs`

## Requirements
- R1: After reset the length and row-count registers read as zero with their forced low bits set, which is 7 in the default build. Both stride registers read 0.
- R2: The low LEN_ALIGN bits of the length register (word address 0) always read as 1, whatever is written. Its upper bits, up to LEN_W=24, hold the written data.
- R3: LEN_ALIGN is the larger of the two ports' contributions. A memory-mapped port contributes 0. A streaming or FIFO port contributes log2 of its bytes per beat. In the default build (a streaming source of 64 bits, a memory-mapped destination of 128 bits) LEN_ALIGN is 3.
- R4: Writing zero with all strobes set to the length register and reading it back returns exactly 2^LEN_ALIGN-1, which is 7 in the default build.
- R5: The source stride (address 2) reads with its low log2(SRC_DATA_W/8) bits cleared, which is 3 bits by default. The destination stride (address 3) clears log2(DST_DATA_W/8) bits, which is 4 bits by default. The bytes-per-beat log2 is 0 for widths up to 8 bits, 1 for widths above 8 bits, 2 above 16, and so on up to 8 above 1024.
- R6: Byte strobe bit b updates bits 8b+7..8b of the addressed register. Lanes whose strobe is low keep their old content. Strobe bit 3 has no effect, because the registers are 24 bits wide.
- R7: With TWO_D_EN=1, the row-count register (address 1) follows the same forcing rule as the length register. With TWO_D_EN=0 it reads 0 and its output is 0.
- R8: When rd_en is high at a clock edge, rd_data takes the value of the addressed register on that edge. The value is zero-extended to 32 bits. Addresses 4 to 7 read 0, and writes to them change nothing.
- R9: The engine-facing outputs equal the readback value of their registers. A write is visible on the outputs from the clock edge that takes it, and the outputs hold steady when no write happens.
- R10: When a read and a write hit the same address on the same edge, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write word address |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Per-byte write enables |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Registered read data |
| xfer_len | output | 24 | Aligned row length (bytes minus one) |
| xfer_rows | output | 24 | Aligned row count for two-dimensional transfers |
| src_stride | output | 24 | Beat-aligned source stride |
| dst_stride | output | 24 | Beat-aligned destination stride |

## Verification
Directed cases cover the reset values, the zero-write discovery read and a write of all ones. Together they separate bits that are forced from bits that were only written. Random writes to all eight addresses, with random data and strobe patterns, set strobed lanes against stale lanes and mapped addresses against unmapped ones. Each random write is checked on both the readback path and the engine outputs. A read and a write to the same address on one edge tells a registered read from a read that bypasses to the new data.

// File: rtl/dma_shape_pkg.sv
package dma_shape_pkg;

  typedef enum logic [1:0] {
    KIND_MEMMAP = 2'd0,
    KIND_STREAM = 2'd1,
    KIND_FIFO   = 2'd2
  } port_kind_e;

  localparam int REG_LEN     = 0;
  localparam int REG_ROWS    = 1;
  localparam int REG_SSTRIDE = 2;
  localparam int REG_DSTRIDE = 3;
  localparam int NUM_REGS    = 4;

  // log2 of bytes per beat, capped ladder on the data width in bits
  function automatic int beat_lg2(input int data_w);
    if (data_w > 1024)     return 8;
    else if (data_w > 512) return 7;
    else if (data_w > 256) return 6;
    else if (data_w > 128) return 5;
    else if (data_w > 64)  return 4;
    else if (data_w > 32)  return 3;
    else if (data_w > 16)  return 2;
    else if (data_w > 8)   return 1;
    else                   return 0;
  endfunction

  // memory-mapped ports impose no length granularity
  function automatic int align_bits(input port_kind_e kind, input int data_w);
    return (kind == KIND_MEMMAP) ? 0 : beat_lg2(data_w);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dma_shape_field.sv
module dma_shape_field #(
  parameter int W       = 24,
  parameter int BUS_W   = 32,
  parameter int ONES_N  = 0,
  parameter int ZERO_N  = 0,
  parameter bit PRESENT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [BUS_W-1:0]   wdata,
  input  logic [BUS_W/8-1:0] wstrb,
  output logic [W-1:0]       q
);

  localparam logic [W-1:0] ONES_MASK = W'((64'd1 << ONES_N) - 64'd1);
  localparam logic [W-1:0] ZERO_MASK = W'((64'd1 << ZERO_N) - 64'd1);

  generate
    if (PRESENT) begin : g_store
      logic [W-1:0] stored;
      logic [W-1:0] bit_en;
      logic         unused_tail;

      for (genvar i = 0; i < W; i++) begin : g_lane
        assign bit_en[i] = wstrb[i/8];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stored <= '0;
        end else if (we) begin
          stored <= (stored & ~bit_en) | (wdata[W-1:0] & bit_en);
        end
      end

      // forcing sits after storage so readback and outputs always agree
      assign q = (stored | ONES_MASK) & ~ZERO_MASK;
      assign unused_tail = ^{wdata, wstrb};
    end else begin : g_absent
      logic unused_in;
      assign unused_in = ^{clk, rst_n, we, wdata, wstrb};
      assign q = '0;
    end
  endgenerate

endmodule

// File: rtl/dma_shape_rdmux.sv
module dma_shape_rdmux #(
  parameter int NUM    = 4,
  parameter int W      = 24,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     rd_addr,
  input  logic [NUM-1:0][W-1:0] vals,
  output logic [BUS_W-1:0]      rd_data
);

  logic [BUS_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM; i++) begin
      if (rd_addr == ADDR_W'(i)) sel = BUS_W'(vals[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= sel;
    end
  end

endmodule

// File: rtl/dma_shape_regs.sv
module dma_shape_regs
  import dma_shape_pkg::*;
#(
  parameter int         BUS_W      = 32,
  parameter int         ADDR_W     = 3,
  parameter int         LEN_W      = 24,
  parameter port_kind_e SRC_KIND   = KIND_STREAM,
  parameter port_kind_e DST_KIND   = KIND_MEMMAP,
  parameter int         SRC_DATA_W = 64,
  parameter int         DST_DATA_W = 128,
  parameter bit         TWO_D_EN   = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [BUS_W-1:0]   wr_data,
  input  logic [BUS_W/8-1:0] wr_strb,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [BUS_W-1:0]   rd_data,
  output logic [LEN_W-1:0]   xfer_len,
  output logic [LEN_W-1:0]   xfer_rows,
  output logic [LEN_W-1:0]   src_stride,
  output logic [LEN_W-1:0]   dst_stride
);

  localparam int LEN_ALIGN = max2(align_bits(SRC_KIND, SRC_DATA_W),
                                  align_bits(DST_KIND, DST_DATA_W));
  localparam int SRC_CLR   = beat_lg2(SRC_DATA_W);
  localparam int DST_CLR   = beat_lg2(DST_DATA_W);

  logic [NUM_REGS-1:0][LEN_W-1:0] field_q;

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_field
      localparam int ONES = (g == REG_LEN || g == REG_ROWS) ? LEN_ALIGN : 0;
      localparam int ZERO = (g == REG_SSTRIDE) ? SRC_CLR :
                            (g == REG_DSTRIDE) ? DST_CLR : 0;
      localparam bit HERE = (g == REG_ROWS) ? TWO_D_EN : 1'b1;
      logic we_g;
      assign we_g = wr_en && (wr_addr == ADDR_W'(g));

      dma_shape_field #(
        .W(LEN_W), .BUS_W(BUS_W), .ONES_N(ONES), .ZERO_N(ZERO), .PRESENT(HERE)
      ) u_field (
        .clk(clk), .rst_n(rst_n), .we(we_g),
        .wdata(wr_data), .wstrb(wr_strb), .q(field_q[g])
      );
    end
  endgenerate

  dma_shape_rdmux #(
    .NUM(NUM_REGS), .W(LEN_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
  ) u_rdmux (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .vals(field_q), .rd_data(rd_data)
  );

  assign xfer_len   = field_q[REG_LEN];
  assign xfer_rows  = field_q[REG_ROWS];
  assign src_stride = field_q[REG_SSTRIDE];
  assign dst_stride = field_q[REG_DSTRIDE];

endmodule

// File: rtl/dma_shape_regs_chk.sv
module dma_shape_regs_chk
  import dma_shape_pkg::*;
#(
  parameter int         BUS_W      = 32,
  parameter int         ADDR_W     = 3,
  parameter int         LEN_W      = 24,
  parameter port_kind_e SRC_KIND   = KIND_STREAM,
  parameter port_kind_e DST_KIND   = KIND_MEMMAP,
  parameter int         SRC_DATA_W = 64,
  parameter int         DST_DATA_W = 128,
  parameter bit         TWO_D_EN   = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [BUS_W-1:0]  rd_data,
  input logic [LEN_W-1:0]  xfer_len,
  input logic [LEN_W-1:0]  xfer_rows,
  input logic [LEN_W-1:0]  src_stride,
  input logic [LEN_W-1:0]  dst_stride
);

  localparam int LA = max2(align_bits(SRC_KIND, SRC_DATA_W), align_bits(DST_KIND, DST_DATA_W));
  localparam logic [LEN_W-1:0] LMASK = LEN_W'((64'd1 << LA) - 64'd1);
  localparam logic [LEN_W-1:0] SMASK = LEN_W'((64'd1 << beat_lg2(SRC_DATA_W)) - 64'd1);
  localparam logic [LEN_W-1:0] DMASK = LEN_W'((64'd1 << beat_lg2(DST_DATA_W)) - 64'd1);

  AST_LEN_LOW_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_len & LMASK) == LMASK); // R2

  AST_STRIDE_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_stride & SMASK) == '0) && ((dst_stride & DMASK) == '0)); // R5

  AST_ROWS_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    TWO_D_EN ? ((xfer_rows & LMASK) == LMASK) : (xfer_rows == '0)); // R7

  AST_READ_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_W'(0)) |=> rd_data == BUS_W'($past(xfer_len))); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(xfer_len) && $stable(xfer_rows) &&
                $stable(src_stride) && $stable(dst_stride))); // R9

endmodule

bind dma_shape_regs dma_shape_regs_chk #(
  .BUS_W(BUS_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SRC_KIND(SRC_KIND),
  .DST_KIND(DST_KIND), .SRC_DATA_W(SRC_DATA_W), .DST_DATA_W(DST_DATA_W),
  .TWO_D_EN(TWO_D_EN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_data(rd_data), .xfer_len(xfer_len), .xfer_rows(xfer_rows),
  .src_stride(src_stride), .dst_stride(dst_stride)
);

// File: tb/dma_shape_regs_tb.sv
module dma_shape_regs_tb;

  localparam logic [23:0] LEN_ONES = 24'h000007; // R3: 64-bit streaming source -> 3 bits
  localparam logic [23:0] SRC_CLR  = 24'h000007; // R5: 8 bytes per beat
  localparam logic [23:0] DST_CLR  = 24'h00000F; // R5: 16 bytes per beat

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_strb = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [23:0] xfer_len, xfer_rows, src_stride, dst_stride;

  int compared = 0;
  int mismatched = 0;
  logic [23:0] raw [4];

  always #2 clk = ~clk;

  dma_shape_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_strb(wr_strb), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .xfer_len(xfer_len), .xfer_rows(xfer_rows),
    .src_stride(src_stride), .dst_stride(dst_stride)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_reg(input int a);
    case (a)
      0: return {8'h0, raw[0] | LEN_ONES};
      1: return {8'h0, raw[1] | LEN_ONES};
      2: return {8'h0, raw[2] & ~SRC_CLR};
      3: return {8'h0, raw[3] & ~DST_CLR};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      0: return "R2";
      1: return "R7";
      2, 3: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic model_write(input int a, input logic [31:0] d, input logic [3:0] s);
    if (a < 4) begin
      for (int b = 0; b < 3; b++) if (s[b]) raw[a][8*b +: 8] = d[8*b +: 8];
    end
  endtask

  task automatic do_write(input int a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d; wr_strb = s;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d, s);
  endtask

  task automatic do_read(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 3'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic check_outputs(input string req);
    check(req, {8'h0, xfer_len},   exp_reg(0));
    check(req, {8'h0, xfer_rows},  exp_reg(1));
    check(req, {8'h0, src_stride}, exp_reg(2));
    check(req, {8'h0, dst_stride}, exp_reg(3));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] old;
    void'($urandom(32'h5EED_0042));
    for (int a = 0; a < 4; a++) raw[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    check_outputs("R1");
    for (int a = 0; a < 8; a++) begin
      do_read(a, d);
      check("R1", d, exp_reg(a));
    end

    // R4 zero write reveals alignment (R3 count)
    do_write(0, 32'h0, 4'hF);
    do_read(0, d);
    check("R4", d, 32'h7);
    check("R3", {8'h0, xfer_len}, 32'h7);

    // R2 all ones and upper bits; R5 all ones into strides
    do_write(0, 32'hFFFF_FFF0, 4'hF);
    do_read(0, d); check("R2", d, 32'h00FF_FFF7);
    do_write(2, 32'hFFFF_FFFF, 4'hF);
    do_read(2, d); check("R5", d, 32'h00FF_FFF8);
    do_write(3, 32'hFFFF_FFFF, 4'hF);
    do_read(3, d); check("R5", d, 32'h00FF_FFF0);
    // R7 row count forcing
    do_write(1, 32'h0000_0100, 4'hF);
    do_read(1, d); check("R7", d, 32'h0000_0107);

    // R6 partial strobes: only middle lane
    do_write(3, 32'h00AB_CD00, 4'b0010);
    do_read(3, d); check("R6", d, 32'h00FF_CDF0);
    // R6 lane 3 only: no effect
    do_write(2, 32'h1200_0000, 4'b1000);
    do_read(2, d); check("R6", d, 32'h00FF_FFF8);

    // R8 unmapped write has no effect on mapped outputs
    do_write(5, 32'h1234_5678, 4'hF);
    check_outputs("R8");
    do_read(5, d); check("R8", d, 32'h0);

    // R10 read and write to the same address on one edge
    old = exp_reg(0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h0000_5550; wr_strb = 4'hF;
    rd_en = 1'b1; rd_addr = 3'd0;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    model_write(0, 32'h0000_5550, 4'hF);
    check("R10", rd_data, old);
    check("R9", {8'h0, xfer_len}, 32'h0000_5557);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int a;
      a = int'($urandom_range(0, 7));
      if ($urandom_range(0, 1) == 0) begin
        do_write(a, $urandom, 4'($urandom_range(0, 15)));
        check_outputs("R9");
      end else begin
        do_read(a, d);
        check(tag_of(a), d, exp_reg(a));
      end
    end

    // R9 outputs hold while idle
    repeat (5) @(negedge clk);
    check_outputs("R9");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule